// File: doc/BRIEF.md
# Serial Sampling ADC Device Model

A synthesizable stand-in for an eight-channel, 16-bit serial sampling converter, placed opposite a controller under test so the controller's serial timing can be exercised without a real converter. Each transfer frame is sixteen serial clocks long and full duplex. The controller shifts a configuration word in while the model shifts out the result of the previous conversion. A rising edge on the convert-start input begins a conversion. The model then holds its busy output high for a fixed number of system clocks and publishes the new result.

The analog side is replaced by a bank of eight sample registers that the surrounding bench writes through a simple write port. A conversion reads one register (single-ended) or the difference of a register pair (differential). The serial clock, serial data and convert-start inputs are asynchronous to the model. They are synchronised to the fast system clock and edge-detected.

The model also watches protocol timing. An acquisition window opens on the sixth serial-clock falling edge of a frame and closes at the next convert-start rising edge. The model raises a sticky flag if that window lasts too long, and another if the convert-start high pulse is too short. Sleep and nap power settings are decoded and only suppress conversions.

Top module: `adc_serial_model`

## Requirements
- R1: After reset, busy_o, sdo_o, acq_o, err_acq_o and err_pulse_o are all 0, and the stored result is 0.
- R2: The result goes out on sdo_o MSB first. Its MSB is present before the first serial-clock rise of a frame, and each serial-clock fall advances one bit. The sdi_i bit is captured on each rise, MSB first. After sixteen rises the word becomes the configuration for the next conversion, and after sixteen falls the result is reloaded for another read.
- R3: Word bits [15:12] are the channel field f. If f[3]=1 the conversion reads sample channel {f[1:0],f[2]}; 1000 selects 0, 1110 selects 5, 1001 selects 2 and 1111 selects 7. Before any word has been received, channel 0 is converted.
- R4: If f[3]=0 the result is sample[{f[1:0],f[2]}] minus sample[{f[1:0],~f[2]}], modulo 2^16. So 0101 gives ch3-ch2 and 0011 gives ch6-ch7.
- R5: Word bits [9:8] are the power field: 0 powered on, 1 sleep, 2 nap. With a non-zero field a convert-start rise starts no conversion: busy_o stays 0 and the result is unchanged.
- R6: A convert-start rise while idle and powered on raises busy_o for exactly CONV_CLK system clocks. The value sampled at that rise becomes the result when busy_o falls.
- R7: While busy_o is 1, sdo_o is 0 and serial-clock edges are ignored. The first frame after busy_o falls starts at the MSB of the new result.
- R8: A convert-start high pulse shorter than CONV_MIN_CLK system clocks sets err_pulse_o, which holds until reset.
- R9: If more than ACQ_MAX_CLK system clocks pass between the sixth serial-clock fall of a frame and the next convert-start rise, err_acq_o is set and holds until reset.
- R10: acq_o goes to 1 after the sixth serial-clock fall of a frame and to 0 at the next convert-start rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from the controller, idle low |
| sdi_i | input | 1 | Serial configuration data from the controller |
| convst_i | input | 1 | Convert start, rising-edge active |
| smp_we_i | input | 1 | Sample register write enable |
| smp_ch_i | input | 3 | Sample register index |
| smp_data_i | input | DATA_W | Sample register write data |
| sdo_o | output | 1 | Serial result data |
| busy_o | output | 1 | Conversion in progress |
| acq_o | output | 1 | Acquisition window open |
| err_acq_o | output | 1 | Sticky: acquisition window too long |
| err_pulse_o | output | 1 | Sticky: convert-start pulse too short |

## Verification
The bench builds the model with CONV_CLK=40, ACQ_MAX_CLK=150 and CONV_MIN_CLK=5. These values keep a whole conversion short, so its exact length is counted cycle by cycle. Busy also lasts long enough for two complete serial-clock periods to land inside it, which exercises the edge-ignore rule. A normal frame keeps the acquisition window under the 150-clock limit, while a deliberate 200-clock pause exceeds it. A 2-clock convert-start pulse falls below the 5-clock minimum.

// File: rtl/adc_model_pkg.sv
package adc_model_pkg;
  localparam int CFG_W  = 16;
  localparam int NUM_CH = 8;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int CHF_HI = 15;  // channel field [15:12]
  localparam int PWR_LO = 8;   // power field [9:8]

  typedef enum logic [1:0] {
    PWR_ON    = 2'd0,
    PWR_SLEEP = 2'd1,
    PWR_NAP   = 2'd2,
    PWR_RSV   = 2'd3
  } pwr_e;

  typedef struct packed {
    logic [3:0] chf;
    pwr_e       pwr;
  } sel_t;

  localparam sel_t SEL_RST = '{chf: 4'b1000, pwr: PWR_ON};

  function automatic logic [CH_W-1:0] pos_idx(input logic [3:0] chf);
    return {chf[1:0], chf[2]};
  endfunction

  function automatic logic [CH_W-1:0] neg_idx(input logic [3:0] chf);
    return {chf[1:0], ~chf[2]};
  endfunction
endpackage

// File: rtl/adc_in_sync.sv
module adc_in_sync #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] in_i,
  output logic [N-1:0] lvl_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [1:0] ff;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff <= '0;
      else         ff <= {ff[0], in_i[g]};
    end
    assign lvl_o[g] = ff[1];
  end
endmodule

// File: rtl/adc_frame_shift.sv
module adc_frame_shift
  import adc_model_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ACQ_EDGE = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              sdi_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              sdo_o,
  output logic              sel_vld_o,
  output sel_t              sel_o,
  output logic              acq_start_o
);
  localparam int CNT_W = $clog2(CFG_W);

  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] out_sh;
  logic [CFG_W-2:0]  in_sh;
  logic [CFG_W-1:0]  word;
  logic              last;

  assign last = (bit_cnt == CNT_W'(CFG_W - 1));
  assign word = {in_sh, sdi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt   <= '0;
      out_sh    <= '0;
      in_sh     <= '0;
      sel_vld_o <= 1'b0;
      sel_o     <= SEL_RST;
    end else begin
      sel_vld_o <= 1'b0;
      if (load_i) begin
        bit_cnt <= '0;
        out_sh  <= load_data_i;
        in_sh   <= '0;
      end else begin
        if (sck_rise_i) begin
          in_sh <= word[CFG_W-2:0];
          if (last) begin
            sel_vld_o <= 1'b1;
            sel_o     <= '{chf: word[CHF_HI -: 4], pwr: pwr_e'(word[PWR_LO +: 2])};
          end
        end
        if (sck_fall_i) begin
          if (last) begin
            bit_cnt <= '0;
            out_sh  <= result_i;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            out_sh  <= out_sh << 1;
          end
        end
      end
    end
  end

  assign sdo_o       = out_sh[DATA_W-1];
  assign acq_start_o = sck_fall_i && !load_i && (bit_cnt == CNT_W'(ACQ_EDGE - 1));
endmodule

// File: rtl/adc_timing_mon.sv
module adc_timing_mon #(
  parameter int ACQ_MAX_CLK  = 500,
  parameter int CONV_MIN_CLK = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acq_start_i,
  input  logic conv_lvl_i,
  input  logic conv_rise_i,
  input  logic conv_fall_i,
  output logic acq_o,
  output logic err_acq_o,
  output logic err_pulse_o
);
  localparam int AW = $clog2(ACQ_MAX_CLK + 2);
  localparam int PW = $clog2(CONV_MIN_CLK + 1);

  logic [AW-1:0] acq_cnt;
  logic [PW-1:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acq_o     <= 1'b0;
      acq_cnt   <= '0;
      err_acq_o <= 1'b0;
    end else if (conv_rise_i) begin
      acq_o <= 1'b0;
      if (acq_o && acq_cnt > AW'(ACQ_MAX_CLK)) err_acq_o <= 1'b1;
    end else if (acq_start_i) begin
      acq_o   <= 1'b1;
      acq_cnt <= '0;
    end else if (acq_o && acq_cnt <= AW'(ACQ_MAX_CLK)) begin
      acq_cnt <= acq_cnt + 1'b1;  // saturates one past the limit
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt      <= '0;
      err_pulse_o <= 1'b0;
    end else if (conv_rise_i) begin
      hi_cnt <= PW'(1);
    end else if (conv_fall_i) begin
      if (hi_cnt < PW'(CONV_MIN_CLK)) err_pulse_o <= 1'b1;
    end else if (conv_lvl_i && hi_cnt < PW'(CONV_MIN_CLK)) begin
      hi_cnt <= hi_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/adc_conv_core.sv
module adc_conv_core
  import adc_model_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CONV_CLK = 400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sel_vld_i,
  input  sel_t              sel_i,
  input  logic              wr_en_i,
  input  logic [CH_W-1:0]   wr_ch_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] hold_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int CW = $clog2(CONV_CLK + 1);

  logic [DATA_W-1:0] bank [NUM_CH];
  sel_t              sel_q;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] sample;
  logic              start_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_CH; i++) bank[i] <= '0;
    end else if (wr_en_i) begin
      bank[wr_ch_i] <= wr_data_i;
    end
  end

  always_comb begin
    sample = bank[pos_idx(sel_q.chf)];
    if (!sel_q.chf[3]) sample = bank[pos_idx(sel_q.chf)] - bank[neg_idx(sel_q.chf)];
  end

  assign start_ok = start_i && !busy_o && (sel_q.pwr == PWR_ON);
  assign done_o   = busy_o && (cnt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= SEL_RST;
      busy_o   <= 1'b0;
      cnt      <= '0;
      hold_o   <= '0;
      result_o <= '0;
    end else begin
      if (sel_vld_i) sel_q <= sel_i;
      if (start_ok) begin
        busy_o <= 1'b1;
        cnt    <= CW'(CONV_CLK - 1);
        hold_o <= sample;
      end else if (busy_o) begin
        if (done_o) begin
          busy_o   <= 1'b0;
          result_o <= hold_o;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_serial_model.sv
module adc_serial_model
  import adc_model_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int CONV_CLK     = 400,
  parameter int ACQ_MAX_CLK  = 500,
  parameter int CONV_MIN_CLK = 5,
  parameter int ACQ_EDGE     = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic              convst_i,
  input  logic              smp_we_i,
  input  logic [2:0]        smp_ch_i,
  input  logic [DATA_W-1:0] smp_data_i,
  output logic              sdo_o,
  output logic              busy_o,
  output logic              acq_o,
  output logic              err_acq_o,
  output logic              err_pulse_o
);
  logic [2:0]        s_lvl;
  logic [1:0]        prev;
  logic              sck_rise, sck_fall, conv_rise, conv_fall;
  logic              busy, done, sel_vld, acq_start, sdo_raw;
  sel_t              sel;
  logic [DATA_W-1:0] hold, result;

  adc_in_sync #(.N(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  ({convst_i, sdi_i, sck_i}),
    .lvl_o (s_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev <= '0;
    else         prev <= {s_lvl[2], s_lvl[0]};
  end

  // serial clock edges are dropped while converting
  assign sck_rise  =  s_lvl[0] & ~prev[0] & ~busy;
  assign sck_fall  = ~s_lvl[0] &  prev[0] & ~busy;
  assign conv_rise =  s_lvl[2] & ~prev[1];
  assign conv_fall = ~s_lvl[2] &  prev[1];

  adc_frame_shift #(.DATA_W(DATA_W), .ACQ_EDGE(ACQ_EDGE)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_rise_i (sck_rise),
    .sck_fall_i (sck_fall),
    .sdi_i      (s_lvl[1]),
    .load_i     (done),
    .load_data_i(hold),
    .result_i   (result),
    .sdo_o      (sdo_raw),
    .sel_vld_o  (sel_vld),
    .sel_o      (sel),
    .acq_start_o(acq_start)
  );

  adc_timing_mon #(.ACQ_MAX_CLK(ACQ_MAX_CLK), .CONV_MIN_CLK(CONV_MIN_CLK)) u_mon (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acq_start_i(acq_start),
    .conv_lvl_i (s_lvl[2]),
    .conv_rise_i(conv_rise),
    .conv_fall_i(conv_fall),
    .acq_o      (acq_o),
    .err_acq_o  (err_acq_o),
    .err_pulse_o(err_pulse_o)
  );

  adc_conv_core #(.DATA_W(DATA_W), .CONV_CLK(CONV_CLK)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (conv_rise),
    .sel_vld_i(sel_vld),
    .sel_i    (sel),
    .wr_en_i  (smp_we_i),
    .wr_ch_i  (smp_ch_i),
    .wr_data_i(smp_data_i),
    .busy_o   (busy),
    .done_o   (done),
    .hold_o   (hold),
    .result_o (result)
  );

  assign busy_o = busy;
  assign sdo_o  = busy ? 1'b0 : sdo_raw;
endmodule

// File: rtl/adc_serial_model_chk.sv
module adc_serial_model_chk #(
  parameter int CONV_CLK = 400
) (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic acq_o,
  input logic err_acq_o,
  input logic err_pulse_o
);
  localparam int BW = $clog2(CONV_CLK + 1) + 1;
  logic [BW-1:0] bcnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bcnt <= '0;
    else if (busy_o) bcnt <= bcnt + 1'b1;
    else             bcnt <= '0;
  end

  p_busy_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> bcnt < BW'(CONV_CLK));
  p_busy_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> bcnt == BW'(CONV_CLK));
  p_acq_closed_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !acq_o);
  p_err_acq_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_acq_o |=> err_acq_o);
  p_err_pulse_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pulse_o |=> err_pulse_o);
endmodule

bind adc_serial_model adc_serial_model_chk #(.CONV_CLK(CONV_CLK)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .acq_o      (acq_o),
  .err_acq_o  (err_acq_o),
  .err_pulse_o(err_pulse_o)
);

// File: tb/sim_adc_serial_model.sv
module sim_adc_serial_model;
  localparam int CONV_CLK     = 40;
  localparam int ACQ_MAX_CLK  = 150;
  localparam int CONV_MIN_CLK = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_ni = 1'b0;
  logic sck = 1'b0, sdi = 1'b0, convst = 1'b0;
  logic smp_we = 1'b0;
  logic [2:0] smp_ch = '0;
  logic [15:0] smp_data = '0;
  logic sdo_o, busy_o, acq_o, err_acq_o, err_pulse_o;

  adc_serial_model #(
    .CONV_CLK(CONV_CLK), .ACQ_MAX_CLK(ACQ_MAX_CLK), .CONV_MIN_CLK(CONV_MIN_CLK)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .sdi_i(sdi), .convst_i(convst),
    .smp_we_i(smp_we), .smp_ch_i(smp_ch), .smp_data_i(smp_data),
    .sdo_o(sdo_o), .busy_o(busy_o), .acq_o(acq_o),
    .err_acq_o(err_acq_o), .err_pulse_o(err_pulse_o)
  );

  int checks = 0, errors = 0;
  int busy_cnt = 0;
  bit done = 0;
  logic [15:0] smp [8];

  always @(negedge clk) if (busy_o) busy_cnt++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [15:0] w, output logic [15:0] r);
    for (int i = 15; i >= 0; i--) begin
      sdi = w[i];
      wait_clk(4);
      r[i] = sdo_o;
      sck = 1'b1;
      wait_clk(4);
      sck = 1'b0;
    end
    wait_clk(4);
  endtask

  task automatic convert(input int width, output int blen);
    int b0;
    b0 = busy_cnt;
    convst = 1'b1;
    wait_clk(width);
    convst = 1'b0;
    wait_clk(CONV_CLK + 10);
    blen = busy_cnt - b0;
  endtask

  task automatic t_reset();
    chk("R1 busy", busy_o, 0);
    chk("R1 sdo", sdo_o, 0);
    chk("R1 acq", acq_o, 0);
    chk("R1 err_acq", err_acq_o, 0);
    chk("R1 err_pulse", err_pulse_o, 0);
    for (int k = 0; k < 8; k++) begin
      smp[k] = 16'h8055 + 16'h0123 * k;
      smp_we = 1'b1; smp_ch = 3'(k); smp_data = smp[k];
      wait_clk(1);
    end
    smp_we = 1'b0;
    wait_clk(2);
  endtask

  task automatic t_default_single();
    logic [15:0] r;
    int blen;
    convert(8, blen);
    chk("R6 busy length", blen, CONV_CLK);
    xfer(16'hE000, r);  // ch5 single-ended
    chk("R3 default ch0 / R2 readout", r, smp[0]);
    chk("R10 acq open after frame", acq_o, 1);
    convert(8, blen);
    chk("R10 acq closed by convst", acq_o, 0);
    xfer(16'h5000, r);  // diff ch3-ch2
    chk("R3 single ch5", r, smp[5]);
  endtask

  task automatic t_diff();
    logic [15:0] r;
    int blen;
    convert(8, blen);
    xfer(16'h3000, r);  // diff ch6-ch7
    chk("R4 diff ch3-ch2", r, 16'(smp[3] - smp[2]));
    convert(8, blen);
    xfer(16'h8100, r);  // ch0, sleep
    chk("R4 diff ch6-ch7 wraps", r, 16'(smp[6] - smp[7]));
    chk("R9 no error on short window", err_acq_o, 0);
  endtask

  task automatic t_power();
    logic [15:0] r;
    int blen;
    convert(8, blen);
    chk("R5 sleep no busy", blen, 0);
    xfer(16'h8200, r);  // ch0, nap
    chk("R5 sleep result unchanged", r, 16'(smp[6] - smp[7]));
    convert(8, blen);
    chk("R5 nap no busy", blen, 0);
    xfer(16'h9000, r);  // ch2, powered on
    chk("R5 nap result unchanged", r, 16'(smp[6] - smp[7]));
    convert(8, blen);
    chk("R6 busy after power on", blen, CONV_CLK);
    xfer(16'hF000, r);  // ch7
    chk("R3 single ch2", r, smp[2]);
  endtask

  task automatic t_busy_gate();
    logic [15:0] r;
    convst = 1'b1;
    wait_clk(8);
    convst = 1'b0;
    chk("R7 busy high", busy_o, 1);
    for (int i = 0; i < 2; i++) begin
      sck = 1'b1; wait_clk(4);
      chk("R7 sdo quiet (sck high)", sdo_o, 0);
      sck = 1'b0; wait_clk(4);
      chk("R7 sdo quiet (sck low)", sdo_o, 0);
    end
    wait_clk(CONV_CLK);
    chk("R7 busy done", busy_o, 0);
    xfer(16'h8000, r);
    chk("R7 frame starts at MSB", r, smp[7]);
    xfer(16'h8000, r);
    chk("R2 reload for second read", r, smp[7]);
  endtask

  task automatic t_pulse();
    int blen;
    chk("R8 no error on wide pulse", err_pulse_o, 0);
    convert(2, blen);
    chk("R8 short pulse flagged", err_pulse_o, 1);
    chk("R9 unaffected by short pulse", err_acq_o, 0);
  endtask

  task automatic t_acq_long();
    logic [15:0] r;
    int blen;
    xfer(16'h8000, r);
    wait_clk(200);
    convert(8, blen);
    chk("R9 long window flagged", err_acq_o, 1);
    chk("R8 error held", err_pulse_o, 1);
  endtask

  initial begin
    wait_clk(3);
    rst_ni = 1'b1;
    wait_clk(2);
    t_reset();
    t_default_single();
    t_diff();
    t_power();
    t_busy_gate();
    t_pulse();
    t_acq_long();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule